// File: doc/BRIEF.md
# Next-PC and Control-Transfer Unit

This block decides where a 32-bit fixed-length RISC core fetches next. Each cycle it takes the current program counter, the instruction word at that address and the value of the instruction's rs source register, as read from the register file. It classifies the instruction as sequential, a conditional branch on rs being zero or non-zero, an absolute jump, or a jump through a register. It then forms the matching target and registers the resulting next PC.

Link variants also ask the register file to write the return address PC+4 into register 31. A register-indirect target that is not word aligned is reported on an illegal-control flag, and fetch falls through to PC+4. All outputs are registered, so a result appears one clock after its inputs are sampled.

Top module: `npc_unit`

## Requirements
- R1: While rst_ni is low, next_pc_o equals the RESET_PC parameter (default 0), and taken_o, link_we_o, link_idx_o, link_val_o and illegal_o are all zero.
- R2: Outputs are registered. The inputs sampled at a rising clock edge decide the outputs held after that edge. An instruction that is not a control transfer gives next_pc_o = pc_i + 4, with taken_o, link_we_o and illegal_o low.
- R3: Opcode 4 (bits 31:26) is a branch on rs (bits 25:21) being zero. When rs_val_i == 0, taken_o is 1 and next_pc_o = pc_i + 4 + (sign-extended bits 15:0) * 4. The rt field (bits 20:16) has no effect.
- R4: Opcode 5 is a branch on rs not zero. It forms the same target as R3 and is taken when rs_val_i != 0.
- R5: A branch whose test fails gives taken_o = 0 and next_pc_o = pc_i + 4. This covers the full offset range, from 0x8000 (-32768 words) to 0x7FFF.
- R6: Opcode 2 is an absolute jump. It is always taken, with next_pc_o = {pc_i[31:28], insn_i[25:0], 2'b00}. The upper bits come from pc_i, not from pc_i + 4.
- R7: Opcode 3 jumps like R6 and also links.
- R8: Opcode 0 with function code 8 (bits 5:0) jumps to rs_val_i and is taken.
- R9: Opcode 0 with function code 9 jumps like R8 and also links.
- R10: For function codes 8 and 9, if rs_val_i[1:0] != 0, then illegal_o is 1, taken_o is 0 and next_pc_o = pc_i + 4. The link from R9 is still requested.
- R11: link_we_o is 1 only for opcode 3 and for opcode 0 with function 9. When it is 1, link_idx_o = 31 and link_val_o = pc_i + 4. When it is 0, both are zero.
- R12: Opcode 0 with any other function code, and every opcode other than 0, 2, 3, 4 and 5, is treated as sequential (R2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| insn_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of register rs |
| next_pc_o | output | 32 | Registered next fetch address |
| taken_o | output | 1 | Control transfer taken |
| link_we_o | output | 1 | Link register write request |
| link_idx_o | output | 5 | Link register index (31 when writing) |
| link_val_o | output | 32 | Return address to write |
| illegal_o | output | 1 | Misaligned register-indirect target |

## Verification
The assertions check every cycle that:
- a result that is not taken always falls through to the previous PC plus four;
- a link request carries index 31 and the return address;
- an illegal flag follows only a misaligned register value;
- absolute jumps keep the PC region bits;
- register jumps land exactly on the register value;
- the zero-test branch outcome matches the register value.

Only the directed scenarios can show the exact arithmetic of the sign-extended offsets at the range ends. They also show that the rt field and unused function codes are ignored, the not-equal branch and the link-free jump variants, and that the reset values hold.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned OPC_W  = 6;
  localparam int unsigned FUNC_W = 6;
  localparam int unsigned RIDX_W = 5;

  localparam logic [OPC_W-1:0]  OPC_RTYPE = 6'd0;
  localparam logic [OPC_W-1:0]  OPC_JMP   = 6'd2;
  localparam logic [OPC_W-1:0]  OPC_JMPL  = 6'd3;
  localparam logic [OPC_W-1:0]  OPC_BRZ   = 6'd4;
  localparam logic [OPC_W-1:0]  OPC_BRNZ  = 6'd5;
  localparam logic [FUNC_W-1:0] FN_JREG   = 6'd8;
  localparam logic [FUNC_W-1:0] FN_JREGL  = 6'd9;

  localparam logic [RIDX_W-1:0] LINK_REG  = 5'd31;

  typedef enum logic [2:0] {
    CK_SEQ,
    CK_BRZ,
    CK_BRNZ,
    CK_JABS,
    CK_JREG
  } ctl_kind_e;

  typedef struct packed {
    ctl_kind_e   kind;
    logic        link;
    logic [15:0] off16;
    logic [25:0] tgt26;
  } ctl_dec_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [31:0] insn_i,
  output ctl_dec_t    dec_o
);
  logic [OPC_W-1:0]  opc;
  logic [FUNC_W-1:0] fn;

  assign opc = insn_i[31:26];
  assign fn  = insn_i[FUNC_W-1:0];

  always_comb begin
    dec_o.kind  = CK_SEQ;
    dec_o.link  = 1'b0;
    dec_o.off16 = insn_i[15:0];
    dec_o.tgt26 = insn_i[25:0];
    unique case (opc)
      OPC_JMP:  dec_o.kind = CK_JABS;
      OPC_JMPL: begin dec_o.kind = CK_JABS; dec_o.link = 1'b1; end
      OPC_BRZ:  dec_o.kind = CK_BRZ;
      OPC_BRNZ: dec_o.kind = CK_BRNZ;
      OPC_RTYPE: begin
        if (fn == FN_JREG)  dec_o.kind = CK_JREG;
        if (fn == FN_JREGL) begin dec_o.kind = CK_JREG; dec_o.link = 1'b1; end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  ctl_dec_t        dec_i,
  output logic [XLEN-1:0] seq_pc_o,
  output logic [XLEN-1:0] br_pc_o,
  output logic [XLEN-1:0] abs_pc_o
);
  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned SEXT_W     = XLEN - 18;
  localparam int unsigned REGION_W   = XLEN - 28;

  logic [XLEN-1:0] br_off;

  assign seq_pc_o = pc_i + XLEN'(INSN_BYTES);
  assign br_off   = {{SEXT_W{dec_i.off16[15]}}, dec_i.off16, 2'b00};
  assign br_pc_o  = seq_pc_o + br_off;
  // region bits come from the current PC, not the sequential one
  assign abs_pc_o = {pc_i[XLEN-1 -: REGION_W], dec_i.tgt26, 2'b00};
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  ctl_dec_t        dec_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] seq_pc_i,
  input  logic [XLEN-1:0] br_pc_i,
  input  logic [XLEN-1:0] abs_pc_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            illegal_o
);
  logic rs_zero;
  logic rs_misal;

  assign rs_zero  = (rs_val_i == '0);
  assign rs_misal = |rs_val_i[1:0];

  always_comb begin
    taken_o   = 1'b0;
    illegal_o = 1'b0;
    next_pc_o = seq_pc_i;
    unique case (dec_i.kind)
      CK_BRZ:  taken_o = rs_zero;
      CK_BRNZ: taken_o = !rs_zero;
      CK_JABS: taken_o = 1'b1;
      CK_JREG: begin
        illegal_o = rs_misal;
        taken_o   = !rs_misal;
      end
      default: ;
    endcase
    if (taken_o) begin
      unique case (dec_i.kind)
        CK_JABS: next_pc_o = abs_pc_i;
        CK_JREG: next_pc_o = rs_val_i;
        default: next_pc_o = br_pc_i;
      endcase
    end
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [31:0]       insn_i,
  input  logic [XLEN-1:0]   rs_val_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_val_o,
  output logic              illegal_o
);
  ctl_dec_t        dec;
  logic [XLEN-1:0] seq_pc, br_pc, abs_pc, nxt_d;
  logic            taken_d, illegal_d;

  npc_decode u_dec (.insn_i(insn_i), .dec_o(dec));

  npc_target #(.XLEN(XLEN)) u_tgt (
    .pc_i(pc_i), .dec_i(dec),
    .seq_pc_o(seq_pc), .br_pc_o(br_pc), .abs_pc_o(abs_pc)
  );

  npc_select #(.XLEN(XLEN)) u_sel (
    .dec_i(dec), .rs_val_i(rs_val_i),
    .seq_pc_i(seq_pc), .br_pc_i(br_pc), .abs_pc_i(abs_pc),
    .next_pc_o(nxt_d), .taken_o(taken_d), .illegal_o(illegal_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o  <= XLEN'(RESET_PC);
      taken_o    <= 1'b0;
      link_we_o  <= 1'b0;
      link_idx_o <= '0;
      link_val_o <= '0;
      illegal_o  <= 1'b0;
    end else begin
      next_pc_o  <= nxt_d;
      taken_o    <= taken_d;
      link_we_o  <= dec.link;
      link_idx_o <= dec.link ? LINK_REG : '0;
      link_val_o <= dec.link ? seq_pc : '0;
      illegal_o  <= illegal_d;
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_i,
  input logic [31:0]     insn_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic [4:0]      link_idx_o,
  input logic [XLEN-1:0] link_val_o,
  input logic            illegal_o
);
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;

  AST_FALLTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && !taken_o |-> next_pc_o == $past(pc_i) + XLEN'(4)); // R5

  AST_LINK_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && link_we_o |-> link_idx_o == 5'd31 && link_val_o == $past(pc_i) + XLEN'(4)); // R11

  AST_ILLEGAL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && illegal_o |-> $past(rs_val_i[1:0]) != 2'b00 && !taken_o); // R10

  AST_JUMP_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && ($past(insn_i[31:26]) == 6'd2 || $past(insn_i[31:26]) == 6'd3)
    |-> taken_o && next_pc_o[XLEN-1 -: 4] == $past(pc_i[XLEN-1 -: 4])); // R6

  AST_REG_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && taken_o && $past(insn_i[31:26]) == 6'd0 |-> next_pc_o == $past(rs_val_i)); // R8

  AST_BRZ_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(insn_i[31:26]) == 6'd4 |-> taken_o == ($past(rs_val_i) == '0)); // R3
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_i), .insn_i(insn_i),
  .rs_val_i(rs_val_i), .next_pc_o(next_pc_o), .taken_o(taken_o),
  .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_val_o(link_val_o),
  .illegal_o(illegal_o)
);

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0, insn_i = '0, rs_val_i = '0;
  logic [31:0] next_pc_o, link_val_o;
  logic        taken_o, link_we_o, illegal_o;
  logic [4:0]  link_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  npc_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_i), .insn_i(insn_i),
    .rs_val_i(rs_val_i), .next_pc_o(next_pc_o), .taken_o(taken_o),
    .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_val_o(link_val_o),
    .illegal_o(illegal_o)
  );

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] t);
    return {op, t};
  endfunction
  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [5:0] fn);
    return {6'd0, rs, 15'd0, fn};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, result registered at posedge, sampled at next negedge
  task automatic run(input string req, input logic [31:0] pc, input logic [31:0] insn,
                     input logic [31:0] rs, input logic [31:0] e_pc, input bit e_tk,
                     input bit e_lnk, input bit e_ill);
    @(negedge clk_i);
    pc_i = pc; insn_i = insn; rs_val_i = rs;
    @(negedge clk_i);
    chk(req, "next_pc", next_pc_o, e_pc);
    chk(req, "taken", 32'(taken_o), 32'(e_tk));
    chk(req, "illegal", 32'(illegal_o), 32'(e_ill));
    chk(req, "link_we", 32'(link_we_o), 32'(e_lnk));
    chk(req, "link_idx", 32'(link_idx_o), e_lnk ? 32'd31 : 32'd0);
    chk(req, "link_val", link_val_o, e_lnk ? pc + 32'd4 : 32'd0);
  endtask

  task automatic t_reset();
    #5;
    chk("R1", "next_pc", next_pc_o, 32'h0);
    chk("R1", "flags", {29'd0, taken_o, link_we_o, illegal_o}, 32'd0);
    chk("R1", "link", {link_idx_o, link_val_o[26:0]}, 32'd0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_seq();
    run("R2", 32'h0000_0100, enc_r(5'd3, 6'd32), 32'h0, 32'h0000_0104, 0, 0, 0);
    run("R12", 32'h0000_0200, enc_i(6'h23, 5'd2, 5'd1, 16'h0010), 32'h0, 32'h0000_0204, 0, 0, 0);
    run("R12", 32'h0000_0300, enc_r(5'd4, 6'd10), 32'h0000_0800, 32'h0000_0304, 0, 0, 0);
  endtask

  task automatic t_branch();
    run("R3", 32'h0000_1000, enc_i(6'd4, 5'd7, 5'd9, 16'h0010), 32'h0, 32'h0000_1044, 1, 0, 0);
    run("R5", 32'h0000_1000, enc_i(6'd4, 5'd7, 5'd0, 16'h0010), 32'h5, 32'h0000_1004, 0, 0, 0);
    run("R4", 32'h0000_2000, enc_i(6'd5, 5'd7, 5'd3, 16'hFFFE), 32'h1, 32'h0000_1FFC, 1, 0, 0);
    run("R5", 32'h0000_2000, enc_i(6'd5, 5'd7, 5'd3, 16'hFFFE), 32'h0, 32'h0000_2004, 0, 0, 0);
    run("R5", 32'h0004_0000, enc_i(6'd4, 5'd1, 5'd0, 16'h8000), 32'h0, 32'h0002_0004, 1, 0, 0);
    run("R5", 32'h0000_0000, enc_i(6'd5, 5'd1, 5'd0, 16'h7FFF), 32'h8000_0000, 32'h0002_0000, 1, 0, 0);
  endtask

  task automatic t_jump();
    run("R6", 32'hA000_0010, enc_j(6'd2, 26'h0123456), 32'h0, 32'hA048_D158, 1, 0, 0);
    run("R7", 32'h5FFF_FFFC, enc_j(6'd3, 26'h3FF_FFFF), 32'h0, 32'h5FFF_FFFC, 1, 1, 0);
  endtask

  task automatic t_reg();
    run("R8", 32'h0000_4000, enc_r(5'd6, 6'd8), 32'h1234_5678, 32'h1234_5678, 1, 0, 0);
    run("R9", 32'h0000_4100, enc_r(5'd6, 6'd9), 32'hCAFE_0000, 32'hCAFE_0000, 1, 1, 0);
    run("R10", 32'h0000_4200, enc_r(5'd6, 6'd8), 32'h1234_5679, 32'h0000_4204, 0, 0, 1);
    run("R10", 32'h0000_4300, enc_r(5'd6, 6'd9), 32'h0000_0002, 32'h0000_4304, 0, 1, 1);
  endtask

  initial begin
    t_reset();
    t_seq();
    t_branch();
    t_jump();
    t_reg();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule